// File: doc/BRIEF.md
# I2C Controller Interrupt Status Aggregator

This block gathers the twelve event sources of an I2C controller into one status word, latches the pulsed ones until software clears them, and folds the enabled ones into a single interrupt line. A mask register picks which sources may raise the line. A companion reason register collects the causes of a transmit abort, so that software can tell a missing acknowledge from lost arbitration.

Software reads the block through a simple strobe port. Each latched source has its own clear-on-read address, so an event that lands between the status read and the clear is never thrown away. One combined clear address also exists for bulk cleanup. Both the receive-full source and the transmit-empty source are levels from the FIFO logic. They follow their inputs and cannot be cleared. The register port is plain control and status, so it carries no valid/ready handshake: a read strobe always completes, with its data one cycle later.

Top module: `intr_status_top`

## Requirements
- R1: Source bit positions are: rx underflow 0, rx overflow 1, rx full 2, tx overflow 3, tx empty 4, read request 5, tx abort 6, rx done 7, activity 8, stop seen 9, start seen 10, general call 11. A one-cycle pulse on `evt_i[n]` of a pulsed source sets raw bit n from the next cycle on, and the bit holds until it is cleared.
- R2: Bits 2 and 4 equal `evt_i[2]` and `evt_i[4]` in the same cycle, and no clear read changes them.
- R3: Masked status equals raw status AND mask. `irq_o` is high exactly when the masked status is non-zero.
- R4: The mask resets to 0x254 (rx full, tx empty, tx abort, stop seen). A write to address 2 loads `wr_data_i`, and a read of address 2 returns the mask.
- R5: Reading address 16+n (n = 0..11) clears only raw bit n and returns that bit's value from before the clear in data bit 0.
- R6: Reading address 4 returns the raw status from before the clear and clears every latched bit.
- R7: When an event pulse arrives in the same cycle as a clear of its bit, the bit stays set.
- R8: The abort reason register (read at address 3) is the sticky OR of `abrt_why_i`. Bits 6 and 8 are reserved and always read 0.
- R9: The abort reason register clears only on a read of address 22 (the tx abort clear). The combined clear leaves it unchanged.
- R10: Read data appears on `rd_data_o` one cycle after `rd_en_i`. Address 0 returns raw status and address 1 returns masked status. Unmapped addresses return 0, and writes to any address other than 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 12 | Event pulses (levels for bits 2 and 4) |
| abrt_why_i | input | 13 | Abort cause pulses |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 5 | Read address |
| rd_data_o | output | 16 | Registered read data |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 5 | Write address |
| wr_data_i | input | 12 | Write data |
| irq_o | output | 1 | Interrupt request |

## Verification
A latched bit, the reason register and the mask each take effect at the clock edge after their pulse or write. Read data is due at the edge after the strobe, and a clear takes effect at that same edge, so a follow-up read sees the cleared state. The level bits and `irq_o` depend on the current inputs with no register in between. The bench drives all inputs at the falling edge and samples at the next falling edge. Each check therefore falls exactly one rising edge after its stimulus. The same-cycle set and clear case is driven in one falling-edge slot.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int NUM_SRC = 12;
  localparam int ABRT_W  = 13;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 16;
  localparam int IDX_W   = $clog2(NUM_SRC);

  localparam logic [NUM_SRC-1:0] LEVEL_SRC  = 12'h014;
  localparam logic [NUM_SRC-1:0] MASK_RESET = 12'h254;
  localparam logic [ABRT_W-1:0]  ABRT_VALID = 13'h1EBF;

  localparam int SRC_TX_ABRT = 6;

  localparam logic [ADDR_W-1:0] A_RAW     = 5'd0;
  localparam logic [ADDR_W-1:0] A_MASKED  = 5'd1;
  localparam logic [ADDR_W-1:0] A_MASK    = 5'd2;
  localparam logic [ADDR_W-1:0] A_REASON  = 5'd3;
  localparam logic [ADDR_W-1:0] A_CLR_ALL = 5'd4;
  localparam logic [ADDR_W-1:0] A_CLR_ONE = 5'd16;
endpackage

// File: rtl/intr_sticky_bit.sv
module intr_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic bit_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bit_o <= 1'b0;
    else if (set_i) bit_o <= 1'b1;
    else if (clr_i) bit_o <= 1'b0;
  end

  assert_set_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> bit_o);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i) |=> bit_o);
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !bit_o);
endmodule

// File: rtl/intr_abort_reason.sv
module intr_abort_reason
  import intr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ABRT_W-1:0] set_i,
  input  logic              clr_i,
  output logic [ABRT_W-1:0] reason_o
);
  logic [ABRT_W-1:0] set_v;
  assign set_v = set_i & ABRT_VALID;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     reason_o <= '0;
    else if (clr_i) reason_o <= set_v;
    else            reason_o <= reason_o | set_v;
  end

  assert_reason_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (($past(reason_o) & ~reason_o) == '0));
  assert_reason_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i == '0) |=> (reason_o == '0));
endmodule

// File: rtl/intr_read_mux.sv
module intr_read_mux
  import intr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  input  logic [NUM_SRC-1:0] raw_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic [ABRT_W-1:0]  reason_i,
  output logic [DATA_W-1:0]  rd_data_o
);
  logic [ADDR_W-1:0] off;
  logic [DATA_W-1:0] sel;

  assign off = rd_addr_i - A_CLR_ONE;

  always_comb begin
    sel = '0;
    if (rd_addr_i == A_RAW || rd_addr_i == A_CLR_ALL) sel = DATA_W'(raw_i);
    else if (rd_addr_i == A_MASKED)                   sel = DATA_W'(raw_i & mask_i);
    else if (rd_addr_i == A_MASK)                     sel = DATA_W'(mask_i);
    else if (rd_addr_i == A_REASON)                   sel = DATA_W'(reason_i);
    else if (rd_addr_i >= A_CLR_ONE && off < ADDR_W'(NUM_SRC))
      sel = DATA_W'(raw_i[off[IDX_W-1:0]]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= sel;
    else              rd_data_o <= '0;
  end
endmodule

// File: rtl/intr_status_top.sv
module intr_status_top
  import intr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [ABRT_W-1:0]  abrt_why_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [NUM_SRC-1:0] wr_data_i,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] raw;
  logic [NUM_SRC-1:0] mask_q;
  logic [ABRT_W-1:0]  reason;
  logic               clr_all;
  logic               clr_reason;

  assign clr_all    = rd_en_i && rd_addr_i == A_CLR_ALL;
  assign clr_reason = rd_en_i && rd_addr_i == (A_CLR_ONE + ADDR_W'(SRC_TX_ABRT));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    if (LEVEL_SRC[g]) begin : g_level
      assign raw[g] = evt_i[g];
    end else begin : g_latch
      logic clr_me;
      assign clr_me = clr_all || (rd_en_i && rd_addr_i == (A_CLR_ONE + ADDR_W'(g)));
      intr_sticky_bit u_bit (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_i[g]),
        .clr_i (clr_me),
        .bit_o (raw[g])
      );
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             mask_q <= MASK_RESET;
    else if (wr_en_i && wr_addr_i == A_MASK) mask_q <= wr_data_i;
  end

  intr_abort_reason u_reason (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (abrt_why_i),
    .clr_i    (clr_reason),
    .reason_o (reason)
  );

  intr_read_mux u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .raw_i     (raw),
    .mask_i    (mask_q),
    .reason_i  (reason),
    .rd_data_o (rd_data_o)
  );

  assign irq_o = |(raw & mask_q);

  assert_masked_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_addr_i == A_MASKED) |=> (rd_data_o == DATA_W'($past(raw) & $past(mask_q))));
  assert_mask_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == A_MASK) |=> (mask_q == $past(wr_data_i)));
  assert_clr_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && evt_i == '0) |=> ((raw & ~LEVEL_SRC) == '0));
endmodule

// File: tb/intr_status_top_tb_top.sv
module intr_status_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] evt = '0;
  logic [12:0] abrt = '0;
  logic        rd_en = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic        irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  intr_status_top dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .abrt_why_i(abrt),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .irq_o(irq)
  );

  // entry: evt[45:34] abrt[33:21] addr[20:16] expected[15:0]
  localparam int NV = 13;
  localparam logic [45:0] VEC [NV] = '{
    {12'h001, 13'h0000, 5'd0,  16'h0001}, // R1 rx underflow latched
    {12'h800, 13'h0000, 5'd0,  16'h0801}, // R1 general call
    {12'h200, 13'h0000, 5'd1,  16'h0200}, // R3 masked by reset mask
    {12'h000, 13'h0009, 5'd3,  16'h0009}, // R8 reasons collected
    {12'h000, 13'h0140, 5'd3,  16'h0009}, // R8 reserved bits dropped
    {12'h000, 13'h0000, 5'd16, 16'h0001}, // R5 clear bit 0 returns old value
    {12'h000, 13'h0000, 5'd0,  16'h0A00}, // R5 only bit 0 cleared
    {12'h040, 13'h1000, 5'd4,  16'h0A40}, // R6 combined clear returns raw
    {12'h000, 13'h0000, 5'd0,  16'h0000}, // R6 all latched bits gone
    {12'h000, 13'h0000, 5'd3,  16'h1009}, // R9 reason kept by combined clear
    {12'h000, 13'h0000, 5'd22, 16'h0000}, // R9 abort clear
    {12'h000, 13'h0000, 5'd3,  16'h0000}, // R9 reason cleared
    {12'h000, 13'h0000, 5'd30, 16'h0000}  // R10 unmapped reads zero
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    d = rd_data; rd_en = 1'b0;
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 irq after reset", {15'd0, irq}, 16'h0000);
    rd(5'd0, d); chk("R1 raw after reset", d, 16'h0000);
    rd(5'd2, d); chk("R4 mask reset", d, 16'h0254);

    // R2 level source: follows input, survives clear
    evt = 12'h004;
    @(negedge clk);
    chk("R3 irq from level", {15'd0, irq}, 16'h0001);
    rd(5'd18, d); chk("R2 level clear read", d, 16'h0001);
    rd(5'd0, d);  chk("R2 level kept after clear", d, 16'h0004);
    evt = '0;
    @(negedge clk);
    chk("R2 level follows input", {15'd0, irq}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      evt = VEC[i][45:34]; abrt = VEC[i][33:21];
      @(negedge clk);
      evt = '0; abrt = '0;
      rd(VEC[i][20:16], d);
      chk($sformatf("vector %0d", i), d, VEC[i][15:0]);
    end

    // R4 mask write, R10 stray write ignored
    wr_en = 1'b1; wr_addr = 5'd2; wr_data = 12'h001;
    @(negedge clk);
    wr_addr = 5'd0; wr_data = 12'hFFF;
    @(negedge clk);
    wr_en = 1'b0;
    rd(5'd2, d); chk("R4/R10 mask after writes", d, 16'h0001);

    evt = 12'h201;
    @(negedge clk);
    evt = '0;
    chk("R3 irq via new mask", {15'd0, irq}, 16'h0001);
    rd(5'd1, d); chk("R3 masked status", d, 16'h0001);

    // R7 set and clear of bit 9 in one cycle
    evt = 12'h200; rd_en = 1'b1; rd_addr = 5'd25;
    @(negedge clk);
    evt = '0; rd_en = 1'b0;
    chk("R7 clear read old value", rd_data, 16'h0001);
    rd(5'd0, d); chk("R7 bit kept", d, 16'h0201);

    rd(5'd16, d); chk("R5 clear bit 0", d, 16'h0001);
    rd(5'd0, d);  chk("R5 other bit untouched", d, 16'h0200);
    chk("R3 irq off when masked out", {15'd0, irq}, 16'h0000);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(negedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule